// File: doc/BRIEF.md
# Commit-Input Skid Buffer

This block sits between the rename stage and the reorder-buffer insertion port of an out-of-order commit stage. Each cycle, rename presents a bundle of up to W instruction records. Each record carries a program counter, a sequence number, a thread id and a kill flag. The bundle is packed from index 0, and its size is given as a count. When the commit stage is idle, or can take only part of the bundle, the leftover records go into an internal FIFO. On later active cycles the block drains that FIFO ahead of fresh rename traffic, so program order is kept.

On an active cycle the block forwards as many records as the rename width allows, counting buffered and incoming records together. Buffered records leave first, oldest first. Incoming records fill the remaining output slots in bundle index order. Any incoming records that are not forwarded are appended to the FIFO, except those whose kill flag is set, which are dropped. The forwarded records appear on registered output slots one cycle later, with a per-slot valid bit. The FIFO occupancy is reported, and a stall request tells rename to hold off when fewer than W free entries remain. A synchronous flush empties the FIFO at once.

The FIFO depth must be a power of two and at least 2×W.

Top module: `skid_commit_buf`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_vld` is all zeros, `level` is 0 and `stall_req` is 0.
- R2: On a cycle with `stage_active`=1 and `flush`=0, the number of valid output slots on the next cycle equals min(W, `in_cnt` + `level`).
- R3: Valid output slots are contiguous from slot 0. Buffered records fill the lowest slots oldest first, then incoming records follow in increasing bundle index starting at index 0.
- R4: Incoming records that are not forwarded on an active cycle are appended to the FIFO in bundle index order. `level` moves by the number pushed minus the number popped in that cycle.
- R5: On a cycle with `stage_active`=0, no slot is valid on the next cycle, and every unkilled record in the bundle is appended to the FIFO.
- R6: A record with its kill bit set (bit j of `in_kill` for bundle index j) never enters the FIFO. If it is forwarded straight from the bundle, it is delivered with its kill bit still set.
- R7: `stall_req` is 1 exactly when DEPTH − `level` < W.
- R8: When `flush`=1, on the next cycle `level` is 0 and no output slot is valid. The bundle presented with the flush is discarded.
- R9: `level` never exceeds DEPTH. Records that do not fit into the space left after the cycle's pops are discarded, and the records already stored keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the FIFO and drop the current bundle |
| stage_active | input | 1 | Commit stage takes records this cycle |
| in_cnt | input | $clog2(W+1) | Number of records in the incoming bundle (0..W) |
| in_pc | input | W×32 | Program counters, record j at bits [j×32 +: 32] |
| in_seq | input | W×16 | Sequence numbers, record j at bits [j×16 +: 16] |
| in_tid | input | W×2 | Thread ids, record j at bits [j×2 +: 2] |
| in_kill | input | W | Kill flag per bundle record |
| out_vld | output | W | Valid bit per output slot, packed from slot 0 |
| out_pc | output | W×32 | Forwarded program counters |
| out_seq | output | W×16 | Forwarded sequence numbers |
| out_tid | output | W×2 | Forwarded thread ids |
| out_kill | output | W | Forwarded kill flags |
| level | output | $clog2(DEPTH+1) | FIFO occupancy |
| stall_req | output | 1 | Backpressure to rename |

## Verification
The cycle of interest is one where the FIFO pops its oldest entries to the output and, in the same cycle, pushes the tail of the incoming bundle. Getting this right needs a correct split point between the two sources and a net update of the occupancy. The table steps provoke it by leaving a few records buffered and then sending a full bundle on an active cycle, so the output slots mix both sources and the remainder spills into the FIFO. A random phase with kills and flushes then repeats the situation many times. Each step is judged by a queue model: it compares the slot contents and order, the valid count and the new level.

// File: rtl/skb_pkg.sv
package skb_pkg;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 16;
  localparam int TID_W = 2;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [SEQ_W-1:0] seq;
    logic [TID_W-1:0] tid;
    logic             kill;
  } skb_rec_t;
endpackage

// File: rtl/skb_fifo.sv
module skb_fifo
  import skb_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(W + 1),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] wr_n,
  input  skb_rec_t      wr_rec [W],
  input  logic [CW-1:0] rd_n,
  output skb_rec_t      rd_rec [W],
  output logic [LW-1:0] level
);
  skb_rec_t      mem [DEPTH];
  logic [PW-1:0] head, tail;

  // storage: no reset, written at tail for each accepted record
  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (!rst && !clr && (i < int'(wr_n)))
        mem[tail + PW'(i)] <= wr_rec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      head  <= head + PW'(rd_n);
      tail  <= tail + PW'(wr_n);
      level <= level + LW'(wr_n) - LW'(rd_n);
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_rd
    assign rd_rec[g] = mem[head + PW'(g)];
  end
endmodule

// File: rtl/skb_route.sv
module skb_route
  import skb_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(W + 1),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          active,
  input  logic [LW-1:0] level,
  input  logic [CW-1:0] in_cnt,
  input  skb_rec_t      in_rec  [W],
  input  skb_rec_t      buf_rec [W],
  output logic [W-1:0]  fwd_vld,
  output skb_rec_t      fwd_rec [W],
  output logic [CW-1:0] pop_n,
  output logic [CW-1:0] push_n,
  output skb_rec_t      push_rec [W]
);
  int lvl_i, cnt_i, nb, nr, room, pk;

  always_comb begin
    lvl_i = int'(level);
    cnt_i = (int'(in_cnt) > W) ? W : int'(in_cnt);
    nb    = active ? ((lvl_i > W) ? W : lvl_i) : 0;
    nr    = active ? ((cnt_i > W - nb) ? W - nb : cnt_i) : 0;
    room  = DEPTH - lvl_i + nb;

    fwd_vld = '0;
    for (int i = 0; i < W; i++) begin
      fwd_rec[i]  = '0;
      push_rec[i] = '0;
    end

    // output slots: buffered records first, then bundle records
    for (int i = 0; i < W; i++) begin
      if (i < nb) begin
        fwd_vld[i] = 1'b1;
        fwd_rec[i] = buf_rec[i];
      end else begin
        for (int j = 0; j < W; j++) begin
          if (j < nr && i == nb + j) begin
            fwd_vld[i] = 1'b1;
            fwd_rec[i] = in_rec[j];
          end
        end
      end
    end

    // leftover bundle records, killed ones removed, compacted
    pk = 0;
    for (int j = 0; j < W; j++) begin
      if (j >= nr && j < cnt_i && !in_rec[j].kill && pk < room) begin
        for (int k = 0; k < W; k++) begin
          if (k == pk) push_rec[k] = in_rec[j];
        end
        pk = pk + 1;
      end
    end

    pop_n  = CW'(nb);
    push_n = CW'(pk);
  end
endmodule

// File: rtl/skid_commit_buf.sv
module skid_commit_buf
  import skb_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(W + 1),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 stage_active,
  input  logic [CW-1:0]        in_cnt,
  input  logic [W*PC_W-1:0]    in_pc,
  input  logic [W*SEQ_W-1:0]   in_seq,
  input  logic [W*TID_W-1:0]   in_tid,
  input  logic [W-1:0]         in_kill,
  output logic [W-1:0]         out_vld,
  output logic [W*PC_W-1:0]    out_pc,
  output logic [W*SEQ_W-1:0]   out_seq,
  output logic [W*TID_W-1:0]   out_tid,
  output logic [W-1:0]         out_kill,
  output logic [LW-1:0]        level,
  output logic                 stall_req
);
  skb_rec_t      in_rec   [W];
  skb_rec_t      buf_rec  [W];
  skb_rec_t      fwd_rec  [W];
  skb_rec_t      push_rec [W];
  skb_rec_t      out_q    [W];
  logic [W-1:0]  fwd_vld, out_vld_q;
  logic [CW-1:0] pop_n, push_n;

  for (genvar g = 0; g < W; g++) begin : g_unpack
    assign in_rec[g] = {in_pc[g*PC_W +: PC_W], in_seq[g*SEQ_W +: SEQ_W],
                        in_tid[g*TID_W +: TID_W], in_kill[g]};
  end

  skb_route #(.W(W), .DEPTH(DEPTH)) u_route (
    .active   (stage_active & ~flush),
    .level    (level),
    .in_cnt   (in_cnt),
    .in_rec   (in_rec),
    .buf_rec  (buf_rec),
    .fwd_vld  (fwd_vld),
    .fwd_rec  (fwd_rec),
    .pop_n    (pop_n),
    .push_n   (push_n),
    .push_rec (push_rec)
  );

  skb_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .clr    (flush),
    .wr_n   (push_n),
    .wr_rec (push_rec),
    .rd_n   (pop_n),
    .rd_rec (buf_rec),
    .level  (level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= '0;
      for (int i = 0; i < W; i++) out_q[i] <= '0;
    end else begin
      out_vld_q <= flush ? '0 : fwd_vld;
      for (int i = 0; i < W; i++) out_q[i] <= fwd_rec[i];
    end
  end

  assign out_vld   = out_vld_q;
  assign stall_req = (int'(level) > DEPTH - W);

  for (genvar g = 0; g < W; g++) begin : g_pack
    assign out_pc[g*PC_W +: PC_W]    = out_q[g].pc;
    assign out_seq[g*SEQ_W +: SEQ_W] = out_q[g].seq;
    assign out_tid[g*TID_W +: TID_W] = out_q[g].tid;
    assign out_kill[g]               = out_q[g].kill;
  end
endmodule

// File: rtl/skid_commit_buf_chk.sv
module skid_commit_buf_chk #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(W + 1),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          stage_active,
  input logic [CW-1:0] in_cnt,
  input logic [W-1:0]  in_kill,
  input logic [W-1:0]  out_vld,
  input logic [LW-1:0] level,
  input logic          stall_req
);
  assert_fwd_count_R2: assert property (@(posedge clk) disable iff (rst)
    (stage_active && !flush) |=>
      ($countones(out_vld) ==
        (((int'($past(in_cnt)) + int'($past(level))) < W) ?
          (int'($past(in_cnt)) + int'($past(level))) : W)));

  assert_packed_slots_R3: assert property (@(posedge clk) disable iff (rst)
    ((out_vld & (out_vld + W'(1))) == '0));

  assert_net_level_R4: assert property (@(posedge clk) disable iff (rst)
    (stage_active && !flush && in_kill == '0 && !stall_req) |=>
      (int'(level) == int'($past(level)) + int'($past(in_cnt)) - $countones(out_vld)));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!stage_active || flush) |=> (out_vld == '0));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(level) <= DEPTH));
endmodule

bind skid_commit_buf skid_commit_buf_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .stage_active (stage_active),
  .in_cnt       (in_cnt),
  .in_kill      (in_kill),
  .out_vld      (out_vld),
  .level        (level),
  .stall_req    (stall_req)
);

// File: tb/sim_skid_commit_buf.sv
`timescale 1ns/1ps
module sim_skid_commit_buf;
  import skb_pkg::*;
  localparam int W     = 4;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(W + 1);
  localparam int LW = $clog2(DEPTH + 1);

  // {active, flush, count[2:0], kill[3:0]}
  localparam int NT = 13;
  localparam logic [8:0] TBL [NT] = '{
    9'b1_0_100_0000, 9'b0_0_011_0000, 9'b0_0_100_0010, 9'b1_0_000_0000,
    9'b1_0_011_0000, 9'b1_0_100_1000, 9'b1_0_010_0011, 9'b0_0_100_0101,
    9'b1_1_100_0000, 9'b1_0_001_0000, 9'b0_0_010_0000, 9'b1_0_100_0000,
    9'b1_0_000_0000
  };

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, stage_active = 1'b0;
  logic [CW-1:0]      in_cnt = '0;
  logic [W*PC_W-1:0]  in_pc = '0;
  logic [W*SEQ_W-1:0] in_seq = '0;
  logic [W*TID_W-1:0] in_tid = '0;
  logic [W-1:0]       in_kill = '0;
  logic [W-1:0]       out_vld, out_kill;
  logic [W*PC_W-1:0]  out_pc;
  logic [W*SEQ_W-1:0] out_seq;
  logic [W*TID_W-1:0] out_tid;
  logic [LW-1:0]      level;
  logic               stall_req;

  int checks = 0, fails = 0, sc = 1;
  bit done = 1'b0;
  skb_rec_t q [$];

  always #10 clk = ~clk;

  skid_commit_buf #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .stage_active(stage_active),
    .in_cnt(in_cnt), .in_pc(in_pc), .in_seq(in_seq), .in_tid(in_tid),
    .in_kill(in_kill), .out_vld(out_vld), .out_pc(out_pc), .out_seq(out_seq),
    .out_tid(out_tid), .out_kill(out_kill), .level(level), .stall_req(stall_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit act, input bit fl, input int cnt, input logic [W-1:0] km);
    skb_rec_t bun [W];
    skb_rec_t ex [W];
    int en = 0, nb, nr;
    bit ok = 1'b1;
    @(negedge clk);
    for (int j = 0; j < W; j++) begin
      bun[j].pc   = PC_W'(32'h1000 + sc * 4);
      bun[j].seq  = SEQ_W'(sc);
      bun[j].tid  = TID_W'(sc);
      bun[j].kill = km[j];
      sc++;
      in_pc[j*PC_W +: PC_W]    = bun[j].pc;
      in_seq[j*SEQ_W +: SEQ_W] = bun[j].seq;
      in_tid[j*TID_W +: TID_W] = bun[j].tid;
    end
    in_kill = km; in_cnt = CW'(cnt); stage_active = act; flush = fl;
    for (int j = 0; j < W; j++) ex[j] = '0;
    if (fl) q.delete();
    else if (act) begin
      nb = (q.size() < W) ? q.size() : W;
      for (int j = 0; j < nb; j++) ex[en++] = q.pop_front();
      nr = (cnt < W - nb) ? cnt : W - nb;
      for (int j = 0; j < nr; j++) ex[en++] = bun[j];
      for (int j = nr; j < cnt; j++)
        if (!bun[j].kill && q.size() < DEPTH) q.push_back(bun[j]);
    end else begin
      for (int j = 0; j < cnt; j++)
        if (!bun[j].kill && q.size() < DEPTH) q.push_back(bun[j]);
    end
    @(posedge clk); #1;
    chk(fl ? "R8 valid mask" : (act ? "R2 valid count" : "R5 idle mask"),
        int'(out_vld), (1 << en) - 1);
    for (int j = 0; j < en; j++) begin
      if (out_seq[j*SEQ_W +: SEQ_W] != ex[j].seq || out_pc[j*PC_W +: PC_W] != ex[j].pc ||
          out_tid[j*TID_W +: TID_W] != ex[j].tid || out_kill[j] != ex[j].kill) begin
        if (ok) begin
          checks++; fails++; ok = 1'b0;
          $display("FAIL R3 slot %0d: got seq %0d kill %0b expected seq %0d kill %0b",
                   j, out_seq[j*SEQ_W +: SEQ_W], out_kill[j], ex[j].seq, ex[j].kill);
        end
      end
    end
    if (ok) checks++;
    chk(fl ? "R8 level" : ((km != '0) ? "R6 level" : "R4 level"), int'(level), q.size());
    chk("R7 stall", int'(stall_req), int'((DEPTH - q.size()) < W));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(out_vld), 0);
    chk("R1 reset level", int'(level), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 post-reset valid", int'(out_vld), 0);
    chk("R1 post-reset stall", int'(stall_req), 0);

    for (int t = 0; t < NT; t++)
      step(TBL[t][8], TBL[t][7], int'(TBL[t][6:4]), TBL[t][3:0]);

    // R9: overfill while idle, then drain in order
    step(1'b0, 1'b0, 4, 4'b0000);
    step(1'b0, 1'b0, 4, 4'b0000);
    step(1'b0, 1'b0, 4, 4'b0000);
    step(1'b1, 1'b0, 0, 4'b0000);
    step(1'b1, 1'b0, 0, 4'b0000);

    // random stalls, kills and flushes against the queue model
    for (int t = 0; t < 400; t++) begin
      bit a, f;
      int c;
      a = ($urandom_range(0, 3) != 0);
      f = ($urandom_range(0, 39) == 0);
      c = stall_req ? 0 : $urandom_range(0, W);
      step(a, f, c, W'($urandom_range(0, 15) & $urandom_range(0, 15)));
    end
    step(1'b1, 1'b0, 0, '0);
    step(1'b1, 1'b0, 0, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule